// File: doc/BRIEF.md
# Core Interrupt and Trap Controller

This block decides which interrupt a small processor core takes next. It receives six level-sensitive maskable request lines and one software request port. The software port carries a kind (general, non-maskable or trap) and a vector operand. The block checks these against a per-line enable register and a single global mask bit. It then presents one winner to the CPU sequencer as a one-cycle take strobe and a vector address. The vector stays held until the sequencer acknowledges it.

Two sources reset the block: an external active-low pin and a watchdog expiry pulse. Either one asserts the internal reset at once. The internal reset is released on a clock edge. Reset is never arbitrated. It drops any vector that is waiting for acknowledge, sets the global mask bit and clears every per-line enable. No hardware line can be taken until software both writes enables and clears the global mask.

Software interrupts differ in how they affect the global mask. General and non-maskable requests set it. A trap leaves it as it was, so the handler of a trap can still be preempted by hardware lines.

Top module: `core_irq_ctrl`

## Requirements
- R1: Driving `ext_rst_n` low or pulsing `wdog_expire` high asynchronously resets the block. While reset is applied and afterwards, `take_strobe` is 0, `intm` is 1 and every enable bit is 0. The internal reset is released on the second rising clock edge after both sources are inactive.
- R2: Reset overrides a taken interrupt that is waiting for acknowledge. After release, a new request is taken without any `cpu_ack`.
- R3: After reset, a request on a hardware line is not taken until software has written its enable bit and pulsed `gie_clr`.
- R4: Hardware line i can be taken only when `mask_q` bit i is 1. A `mask_we` pulse loads `mask_wdata`, and the new value takes effect from the next cycle.
- R5: A software request with `sw_kind` = 0 (general) is taken with vector `sw_vec` and sets `intm` to 1.
- R6: A software request with `sw_kind` = 1 (non-maskable) is taken with vector 0x24 and sets `intm` to 1, even when `intm` is already 1. `sw_kind` = 3 is no request.
- R7: A software request with `sw_kind` = 2 (trap) is taken with vector 0x22 and leaves `intm` unchanged.
- R8: While `intm` is 1, no hardware line is taken. Software requests are taken regardless of `intm`.
- R9: Among eligible hardware lines, the lowest-numbered one wins. Line i gets vector 2*(i+1), so the lines map to 0x02 up to 0x0C.
- R10: A valid software request in the same cycle as an eligible hardware line is taken first.
- R11: Taking a hardware line sets `intm`. `gie_clr` clears `intm`, but a same-cycle take that sets the mask wins over it.
- R12: `take_strobe` is high for one cycle only. `vec_addr` stays stable until `cpu_ack`. While an acknowledge is pending, nothing is taken and software requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| wdog_expire | input | 1 | Watchdog expiry, active high, asynchronous reset source |
| irq_req | input | 6 | Level requests of the maskable core lines |
| mask_we | input | 1 | Write strobe for the enable register |
| mask_wdata | input | 6 | Enable register write data, 1 = line enabled |
| gie_clr | input | 1 | Clears the global mask bit |
| sw_req | input | 1 | Software interrupt request, one cycle |
| sw_kind | input | 2 | 0 general, 1 non-maskable, 2 trap, 3 none |
| sw_vec | input | 6 | Vector operand of a general software request |
| cpu_ack | input | 1 | Sequencer acknowledge of the held vector |
| take_strobe | output | 1 | One-cycle take indication |
| vec_addr | output | 6 | Vector address of the taken interrupt |
| intm | output | 1 | Global mask bit, 1 = maskable lines blocked |

## Verification
A request present before rising edge k shows up as `take_strobe`, `vec_addr` and the updated `intm` right after edge k, so each take is due one cycle after it is applied. `gie_clr` and `mask_we` change the state after one edge, which means a hardware take that depends on them comes one edge later again. After reset sources go inactive, the internal reset lifts at the second edge. The bench drives every input just after a rising edge and samples the outputs one nanosecond after the next edge, so each check reads exactly the cycle in which its result is due.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;
  localparam int N_LINES = 6;
  localparam int VEC_W   = 6;

  typedef enum logic [1:0] {
    SWK_GENERAL = 2'd0,
    SWK_NMI     = 2'd1,
    SWK_TRAP    = 2'd2,
    SWK_NONE    = 2'd3
  } swk_e;

  localparam logic [VEC_W-1:0] NMI_VEC  = VEC_W'(6'h24);
  localparam logic [VEC_W-1:0] TRAP_VEC = VEC_W'(6'h22);

  function automatic logic [VEC_W-1:0] line_vec(input int idx);
    return VEC_W'((idx + 1) * 2);
  endfunction
endpackage

// File: rtl/core_irq_rstgen.sv
module core_irq_rstgen (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic wdog_expire,
  output logic rst_n_o
);
  logic src_n;
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign src_n = ext_rst_n & ~wdog_expire;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge src_n) begin
    if (!src_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/core_irq_mask_reg.sv
module core_irq_mask_reg
  import core_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [N_LINES-1:0] wdata,
  output logic [N_LINES-1:0] mask_o
);
  logic [N_LINES-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (we) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mask_o == $past(wdata))) else $error("mask load"); // R4
endmodule

// File: rtl/core_irq_pick.sv
module core_irq_pick
  import core_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle,
  input  logic               intm_i,
  input  logic [N_LINES-1:0] req,
  input  logic [N_LINES-1:0] mask,
  input  logic               sw_req,
  input  logic [1:0]         sw_kind,
  input  logic [VEC_W-1:0]   sw_vec,
  output logic               grant,
  output logic               grant_hw,
  output logic               grant_sets_intm,
  output logic [VEC_W-1:0]   grant_vec
);
  logic               sw_valid;
  logic [N_LINES-1:0] elig;
  logic [N_LINES-1:0] line_hit;
  logic [VEC_W-1:0]   hw_vec;
  logic [VEC_W-1:0]   sw_sel_vec;
  swk_e               kind;

  assign kind     = swk_e'(sw_kind);
  assign sw_valid = idle & sw_req & (kind != SWK_NONE);
  assign elig     = req & mask & {N_LINES{idle & ~intm_i & ~sw_valid}};

  // lowest index wins: scan from top so the lowest overwrites last
  always_comb begin
    line_hit = '0;
    hw_vec   = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (elig[i]) begin
        line_hit    = '0;
        line_hit[i] = 1'b1;
        hw_vec      = line_vec(i);
      end
    end
  end

  always_comb begin
    case (kind)
      SWK_NMI:  sw_sel_vec = NMI_VEC;
      SWK_TRAP: sw_sel_vec = TRAP_VEC;
      default:  sw_sel_vec = sw_vec;
    endcase
  end

  assign grant_hw        = |line_hit;
  assign grant           = sw_valid | grant_hw;
  assign grant_vec       = sw_valid ? sw_sel_vec : hw_vec;
  assign grant_sets_intm = grant_hw | (sw_valid & (kind != SWK_TRAP));

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_hit)) else $error("multi line"); // R9
  AST_INTM_BLOCKS_HW: assert property (@(posedge clk) disable iff (!rst_n)
    intm_i |-> !grant_hw) else $error("hw under intm"); // R8
  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !grant) else $error("take while busy"); // R12
  AST_SW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sw_req && kind != SWK_NONE) |-> !grant_hw) else $error("sw order"); // R10
endmodule

// File: rtl/core_irq_ctrl.sv
module core_irq_ctrl
  import core_irq_pkg::*;
(
  input  logic               clk,
  input  logic               ext_rst_n,
  input  logic               wdog_expire,
  input  logic [N_LINES-1:0] irq_req,
  input  logic               mask_we,
  input  logic [N_LINES-1:0] mask_wdata,
  input  logic               gie_clr,
  input  logic               sw_req,
  input  logic [1:0]         sw_kind,
  input  logic [VEC_W-1:0]   sw_vec,
  input  logic               cpu_ack,
  output logic               take_strobe,
  output logic [VEC_W-1:0]   vec_addr,
  output logic               intm
);
  logic               rst_n;
  logic [N_LINES-1:0] mask_q;
  logic               busy_q, busy_d;
  logic               strobe_q, strobe_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic               intm_q, intm_d;
  logic               grant, grant_hw, grant_sets_intm;
  logic [VEC_W-1:0]   grant_vec;

  core_irq_rstgen u_rst (
    .clk(clk), .ext_rst_n(ext_rst_n), .wdog_expire(wdog_expire), .rst_n_o(rst_n)
  );

  core_irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(mask_wdata), .mask_o(mask_q)
  );

  core_irq_pick u_pick (
    .clk(clk), .rst_n(rst_n), .idle(~busy_q), .intm_i(intm_q),
    .req(irq_req), .mask(mask_q), .sw_req(sw_req), .sw_kind(sw_kind),
    .sw_vec(sw_vec), .grant(grant), .grant_hw(grant_hw),
    .grant_sets_intm(grant_sets_intm), .grant_vec(grant_vec)
  );

  always_comb begin
    strobe_d = grant;
    busy_d   = busy_q ? ~cpu_ack : grant;
    vec_d    = grant ? grant_vec : vec_q;
    intm_d   = intm_q;
    if (gie_clr)                 intm_d = 1'b0;
    if (grant && grant_sets_intm) intm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
      vec_q    <= '0;
      intm_q   <= 1'b1;
    end else begin
      busy_q   <= busy_d;
      strobe_q <= strobe_d;
      vec_q    <= vec_d;
      intm_q   <= intm_d;
    end
  end

  assign take_strobe = strobe_q;
  assign vec_addr    = vec_q;
  assign intm        = intm_q;

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_strobe |=> !take_strobe) else $error("strobe width"); // R12
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cpu_ack) |=> ($stable(vec_addr) && busy_q)) else $error("vec moved"); // R12
  AST_HW_SETS_INTM: assert property (@(posedge clk) disable iff (!rst_n)
    grant_hw |=> intm) else $error("intm not set"); // R11
  AST_TRAP_KEEPS_INTM: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && sw_req && sw_kind == SWK_TRAP && !gie_clr) |=> (intm == $past(intm)))
    else $error("trap changed intm"); // R7
  AST_NMI_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && sw_req && sw_kind == SWK_NMI) |=> (take_strobe && vec_addr == NMI_VEC && intm))
    else $error("nmi take"); // R6
endmodule

// File: tb/core_irq_ctrl_tb.sv
module core_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       ext_rst_n, wdog_expire;
  logic [5:0] irq_req, mask_wdata, sw_vec;
  logic       mask_we, gie_clr, sw_req, cpu_ack;
  logic [1:0] sw_kind;
  logic       take_strobe, intm;
  logic [5:0] vec_addr;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  core_irq_ctrl dut_i (
    .clk(clk), .ext_rst_n(ext_rst_n), .wdog_expire(wdog_expire),
    .irq_req(irq_req), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .gie_clr(gie_clr), .sw_req(sw_req), .sw_kind(sw_kind), .sw_vec(sw_vec),
    .cpu_ack(cpu_ack), .take_strobe(take_strobe), .vec_addr(vec_addr), .intm(intm)
  );

  // {irq_req, mask, expect take, expect vector}
  localparam logic [18:0] TBL [8] = '{
    {6'b000001, 6'b111111, 1'b1, 6'h02},
    {6'b100000, 6'b111111, 1'b1, 6'h0C},
    {6'b101100, 6'b111111, 1'b1, 6'h06},
    {6'b101100, 6'b111011, 1'b1, 6'h08},
    {6'b001000, 6'b110111, 1'b0, 6'h00},
    {6'b111111, 6'b111110, 1'b1, 6'h04},
    {6'b000000, 6'b111111, 1'b0, 6'h00},
    {6'b010000, 6'b010000, 1'b1, 6'h0A}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    mask_we = 0; gie_clr = 0; sw_req = 0; cpu_ack = 0; sw_kind = 2'd3;
  endtask

  task automatic ack();
    quiet(); cpu_ack = 1; step(); cpu_ack = 0;
  endtask

  task automatic sw_issue(input logic [1:0] k, input logic [5:0] v);
    quiet(); sw_req = 1; sw_kind = k; sw_vec = v; step(); quiet();
  endtask

  initial begin
    while (cyc < 5000) begin @(posedge clk); cyc++; end
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    ext_rst_n = 0; wdog_expire = 0; irq_req = 0; mask_wdata = 0; sw_vec = 0;
    quiet();
    step(); step();
    chk("R1 reset strobe", take_strobe, 0);
    chk("R1 reset intm", intm, 1);
    ext_rst_n = 1;
    step(); step(); step();

    // R3: request without enables / global clear
    irq_req = 6'b000001;
    step(); step();
    chk("R3 no take after reset", take_strobe, 0);
    mask_we = 1; mask_wdata = 6'h3F; step(); quiet();
    step();
    chk("R8 intm blocks hw", take_strobe, 0);
    gie_clr = 1; step(); quiet();
    chk("R11 gie_clr clears intm", intm, 0);
    step();
    chk("R3 take after enable", take_strobe, 1);
    chk("R9 line0 vector", vec_addr, 6'h02);
    chk("R11 hw take sets intm", intm, 1);
    step();
    chk("R12 strobe one cycle", take_strobe, 0);
    sw_issue(2'd0, 6'h2A);
    chk("R12 sw dropped while busy", take_strobe, 0);
    chk("R12 vector held", vec_addr, 6'h02);
    irq_req = 0;
    ack();
    step();
    chk("R12 no take after ack", take_strobe, 0);

    // table walk: R4 R9
    for (int i = 0; i < 8; i++) begin
      quiet(); irq_req = 0; mask_we = 1; mask_wdata = TBL[i][12:7]; gie_clr = 1;
      step(); quiet();
      irq_req = TBL[i][18:13];
      step();
      chk($sformatf("R9/R4 row%0d take", i), take_strobe, TBL[i][6]);
      if (TBL[i][6]) begin
        chk($sformatf("R9/R4 row%0d vec", i), vec_addr, TBL[i][5:0]);
        irq_req = 0;
        ack();
      end
      irq_req = 0;
    end

    // R5 general software with intm set
    quiet(); step();
    chk("R8 intm before sw", intm, 1);
    sw_issue(2'd0, 6'h2A);
    chk("R5 general take", take_strobe, 1);
    chk("R5 general vec", vec_addr, 6'h2A);
    chk("R5 general intm", intm, 1);
    ack();

    // R7 trap keeps intm clear
    gie_clr = 1; step(); quiet();
    sw_issue(2'd2, 6'h3F);
    chk("R7 trap vec", vec_addr, 6'h22);
    chk("R7 trap intm kept", intm, 0);
    ack();

    // R6 nmi sets intm; kind 3 ignored
    sw_issue(2'd3, 6'h11);
    chk("R6 kind3 no take", take_strobe, 0);
    sw_issue(2'd1, 6'h11);
    chk("R6 nmi vec", vec_addr, 6'h24);
    chk("R6 nmi intm", intm, 1);
    ack();

    // R10 software ahead of hardware
    quiet(); mask_we = 1; mask_wdata = 6'h3F; gie_clr = 1; step(); quiet();
    irq_req = 6'b000001; sw_req = 1; sw_kind = 2'd0; sw_vec = 6'h15;
    step(); quiet();
    chk("R10 sw first", vec_addr, 6'h15);
    ack();
    gie_clr = 1; step(); quiet();
    step();
    chk("R10 hw after sw", vec_addr, 6'h02);
    irq_req = 0; ack();

    // R11 same-cycle take and gie_clr
    gie_clr = 1; step(); quiet();
    irq_req = 6'b000100; gie_clr = 1; step(); quiet();
    chk("R11 take beats clear", intm, 1);
    chk("R11 take vec", vec_addr, 6'h06);

    // R2 watchdog during pending acknowledge
    #1 wdog_expire = 1;
    #1;
    chk("R2 reset intm", intm, 1);
    chk("R2 reset strobe", take_strobe, 0);
    #1 wdog_expire = 0;
    irq_req = 0;
    step(); step(); step();
    irq_req = 6'b000001; gie_clr = 1; step(); quiet(); step();
    chk("R1 mask cleared by watchdog", take_strobe, 0);
    irq_req = 0;
    sw_issue(2'd0, 6'h33);
    chk("R2 take without ack", take_strobe, 1);
    chk("R2 vec", vec_addr, 6'h33);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule